// File: doc/BRIEF.md
# Register File with Delayed Load

This block holds a processor's general-purpose registers: 32 entries of 32 bits, two combinational read ports and one direct write port. Loads from memory do not land at once. Each scheduled load is parked in a single pending slot that holds a target index, a value and a bit mask. The slot retires into the array only when the next load is scheduled or when a flush pulse arrives. A read in the cycle after a load is scheduled therefore still returns the register's old contents.

Retiring a load merges the value into the target under the mask: bits where the mask is 1 take the new value, and bits where it is 0 keep what the register held. A byte or halfword load can therefore update part of a word and leave the rest unchanged. Register 0 is hard-wired to zero. Neither the direct write port nor a retiring load can change it.

Instruction decode, memory access and stall control are not part of this block. The surrounding pipeline drives one-cycle schedule and flush pulses.

Top module: `dlreg_file`

## Requirements
- R1: While reset is asserted, every register reads 0 and the pending slot is empty (target 0, mask 0). A load scheduled as the first action after reset therefore commits nothing to any register.
- R2: The two read ports are combinational and independent. Each port returns the current contents of the register it selects, in the same cycle.
- R3: A direct write (`wr_en` = 1) to a nonzero index stores `wr_val` at the next rising edge. A direct write to index 0 is ignored, and index 0 always reads 0.
- R4: A schedule pulse first commits the load held in the pending slot. At the same edge it replaces the slot with `ld_idx`, `ld_val` and `ld_mask`.
- R5: A commit writes (old & ~mask) | (value & mask) into the target. Bits where the mask is 0 keep their old contents.
- R6: A pending load whose target is index 0 is dropped at commit and changes no register.
- R7: A flush pulse commits the pending load and leaves the slot empty. A second flush with nothing pending changes no register.
- R8: A pending load is not visible on the read ports. Until it commits, its target reads its old value.
- R9: When a direct write and a commit reach the same register at the same edge, the register takes the direct write value.
- R10: Schedule and flush asserted together act as a flush. The pending load commits, the offered new load is discarded, and the slot is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; takes effect at once and is released through a two-flop synchronizer |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_val | output | 32 | Read port 0 data |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_val | output | 32 | Read port 1 data |
| wr_en | input | 1 | Direct write enable |
| wr_idx | input | 5 | Direct write register index |
| wr_val | input | 32 | Direct write data |
| ld_sched | input | 1 | One-cycle pulse that schedules a load |
| ld_idx | input | 5 | Target index of the scheduled load |
| ld_val | input | 32 | Value of the scheduled load |
| ld_mask | input | 32 | Bits of the target that the scheduled load replaces |
| ld_flush | input | 1 | One-cycle pulse that retires the pending load |

## Verification
Reads are combinational. A direct write or a commit becomes visible on the read ports right after the rising edge that samples it, so each check moves the read index a short time after that edge and compares the data before the next falling edge. A scheduled value reaches its target only at the edge of the following schedule or flush. The stimulus table therefore checks each load's target one step after it is scheduled (R8 old value expected) and again after the retiring pulse (R4/R5/R7 merged value expected). Reset is checked while `rst_n` is still low, because it clears the array without waiting for a clock edge.

// File: rtl/dlreg_pkg.sv
package dlreg_pkg;

  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_DATA_W   = 32;

  // Source that updates one array entry on a given edge
  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_DIRECT = 2'd1,
    UPD_COMMIT = 2'd2
  } upd_src_e;

endpackage

// File: rtl/dlreg_rst_sync.sv
module dlreg_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/dlreg_pend_slot.sv
module dlreg_pend_slot #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic [DATA_W-1:0] ld_mask_i,
  output logic              cm_en_o,
  output logic [IDX_W-1:0]  cm_idx_o,
  output logic [DATA_W-1:0] cm_val_o,
  output logic [DATA_W-1:0] cm_mask_o
);

  logic [IDX_W-1:0]  pend_idx_q,  pend_idx_d;
  logic [DATA_W-1:0] pend_val_q,  pend_val_d;
  logic [DATA_W-1:0] pend_mask_q, pend_mask_d;
  logic              slot_en;

  // Any pulse retires the held load; flush wins over schedule
  assign slot_en = sched_i | flush_i;

  always_comb begin
    pend_idx_d  = pend_idx_q;
    pend_val_d  = pend_val_q;
    pend_mask_d = pend_mask_q;
    if (flush_i) begin
      pend_idx_d  = '0;
      pend_val_d  = '0;
      pend_mask_d = '0;
    end else if (sched_i) begin
      pend_idx_d  = ld_idx_i;
      pend_val_d  = ld_val_i;
      pend_mask_d = ld_mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idx_q  <= '0;
      pend_val_q  <= '0;
      pend_mask_q <= '0;
    end else if (slot_en) begin
      pend_idx_q  <= pend_idx_d;
      pend_val_q  <= pend_val_d;
      pend_mask_q <= pend_mask_d;
    end
  end

  // A load aimed at index 0 is dropped at retire time
  assign cm_en_o   = slot_en && (pend_idx_q != '0);
  assign cm_idx_o  = pend_idx_q;
  assign cm_val_o  = pend_val_q;
  assign cm_mask_o = pend_mask_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (pend_idx_q == '0) && (pend_mask_q == '0)); // R7

  AST_BOTH_PULSES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && sched_i) |=> (cm_en_o == 1'b0) || !(sched_i || flush_i)); // R10

  AST_SCHED_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_i && !flush_i) |=> (pend_idx_q == $past(ld_idx_i)) &&
                              (pend_val_q == $past(ld_val_i)) &&
                              (pend_mask_q == $past(ld_mask_i))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sched_i || flush_i) |=> $stable(pend_idx_q) && $stable(pend_mask_q)); // R8

endmodule

// File: rtl/dlreg_array.sv
module dlreg_array
  import dlreg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [DATA_W-1:0]                 wr_val_i,
  input  logic                              cm_en_i,
  input  logic [IDX_W-1:0]                  cm_idx_i,
  input  logic [DATA_W-1:0]                 cm_val_i,
  input  logic [DATA_W-1:0]                 cm_mask_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  // Entry 0 is a constant; it has no storage
  assign regs_q[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_entry
    upd_src_e          src;
    logic [DATA_W-1:0] ent_d;
    logic              ent_en;

    always_comb begin
      src = UPD_NONE;
      if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        src = UPD_DIRECT;
      end else if (cm_en_i && (cm_idx_i == IDX_W'(g))) begin
        src = UPD_COMMIT;
      end
    end

    always_comb begin
      ent_en = 1'b0;
      ent_d  = regs_q[g];
      case (src)
        UPD_DIRECT: begin
          ent_en = 1'b1;
          ent_d  = wr_val_i;
        end
        UPD_COMMIT: begin
          ent_en = 1'b1;
          ent_d  = (regs_q[g] & ~cm_mask_i) | (cm_val_i & cm_mask_i);
        end
        default: begin
          ent_en = 1'b0;
          ent_d  = regs_q[g];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (ent_en) begin
        regs_q[g] <= ent_d;
      end
    end
  end

  assign regs_o = regs_q;

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_idx_i != '0)) |=> regs_q[$past(wr_idx_i)] == $past(wr_val_i)); // R3

  AST_COMMIT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_en_i && !(wr_en_i && (wr_idx_i == cm_idx_i))) |=>
      regs_q[$past(cm_idx_i)] == (($past(regs_q[cm_idx_i]) & ~$past(cm_mask_i)) |
                                  ($past(cm_val_i) & $past(cm_mask_i)))); // R5

  AST_WRITE_BEATS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && cm_en_i && (wr_idx_i == cm_idx_i) && (wr_idx_i != '0)) |=>
      regs_q[$past(wr_idx_i)] == $past(wr_val_i)); // R9

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !cm_en_i) |=> $stable(regs_q)); // R8

endmodule

// File: rtl/dlreg_rdport.sv
module dlreg_rdport #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]               data_o
);

  always_comb begin
    data_o = regs_i[idx_i];
  end

endmodule

// File: rtl/dlreg_file.sv
module dlreg_file
  import dlreg_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_val,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_val,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              ld_sched,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_val,
  input  logic [DATA_W-1:0] ld_mask,
  input  logic              ld_flush
);

  logic                            rst_sync_n;
  logic                            cm_en;
  logic [IDX_W-1:0]                cm_idx;
  logic [DATA_W-1:0]               cm_val;
  logic [DATA_W-1:0]               cm_mask;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  dlreg_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  dlreg_pend_slot #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sched_i   (ld_sched),
    .flush_i   (ld_flush),
    .ld_idx_i  (ld_idx),
    .ld_val_i  (ld_val),
    .ld_mask_i (ld_mask),
    .cm_en_o   (cm_en),
    .cm_idx_o  (cm_idx),
    .cm_val_o  (cm_val),
    .cm_mask_o (cm_mask)
  );

  dlreg_array #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_val_i  (wr_val),
    .cm_en_i   (cm_en),
    .cm_idx_i  (cm_idx),
    .cm_val_i  (cm_val),
    .cm_mask_i (cm_mask),
    .regs_o    (regs)
  );

  dlreg_rdport #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_rd0 (
    .idx_i  (rd0_idx),
    .regs_i (regs),
    .data_o (rd0_val)
  );

  dlreg_rdport #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_rd1 (
    .idx_i  (rd1_idx),
    .regs_i (regs),
    .data_o (rd1_val)
  );

  AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd0_idx == '0) |-> (rd0_val == '0)); // R3

  AST_ZERO_TARGET_DROPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((ld_sched || ld_flush) && (cm_idx == '0)) |-> !cm_en); // R6

endmodule

// File: tb/dlreg_file_tb.sv
module dlreg_file_tb;

  logic        clk;
  logic        rst_n;
  logic [4:0]  rd0_idx, rd1_idx, wr_idx, ld_idx;
  logic [31:0] rd0_val, rd1_val, wr_val, ld_val, ld_mask;
  logic        wr_en, ld_sched, ld_flush;

  int n_checks;
  int n_errors;

  dlreg_file u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_idx  (rd0_idx),
    .rd0_val  (rd0_val),
    .rd1_idx  (rd1_idx),
    .rd1_val  (rd1_val),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val),
    .ld_sched (ld_sched),
    .ld_idx   (ld_idx),
    .ld_val   (ld_val),
    .ld_mask  (ld_mask),
    .ld_flush (ld_flush)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: op[111:110] idx[109:105] val[104:73] mask[72:41] chk[40:36] exp[35:4] req[3:0]
  // op: 0 idle, 1 direct write, 2 schedule, 3 flush
  localparam int NVEC = 10;
  localparam logic [111:0] VECS [0:NVEC-1] = '{
    {2'd1, 5'd5, 32'hAAAA5555, 32'h00000000, 5'd5, 32'hAAAA5555, 4'd3},  // R3 write
    {2'd1, 5'd0, 32'hFFFFFFFF, 32'h00000000, 5'd0, 32'h00000000, 4'd3},  // R3 r0 ignored
    {2'd2, 5'd5, 32'h000000CC, 32'h000000FF, 5'd5, 32'hAAAA5555, 4'd8},  // R8 delay slot
    {2'd0, 5'd0, 32'h00000000, 32'h00000000, 5'd5, 32'hAAAA5555, 4'd8},  // R8 still pending
    {2'd2, 5'd7, 32'h12345678, 32'hFFFFFFFF, 5'd5, 32'hAAAA55CC, 4'd5},  // R4 R5 byte merge
    {2'd2, 5'd7, 32'hDEAD0000, 32'hFFFF0000, 5'd7, 32'h12345678, 4'd4},  // R4 replace slot
    {2'd3, 5'd0, 32'h00000000, 32'h00000000, 5'd7, 32'hDEAD5678, 4'd7},  // R7 flush merges
    {2'd3, 5'd0, 32'h00000000, 32'h00000000, 5'd7, 32'hDEAD5678, 4'd7},  // R7 empty flush
    {2'd2, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h00000000, 4'd6},  // R6 target r0
    {2'd3, 5'd0, 32'h00000000, 32'h00000000, 5'd0, 32'h00000000, 4'd6}   // R6 dropped
  };

  task automatic idle_inputs();
    wr_en = 1'b0; wr_idx = '0; wr_val = '0;
    ld_sched = 1'b0; ld_flush = 1'b0; ld_idx = '0; ld_val = '0; ld_mask = '0;
  endtask

  // Drive one cycle of stimulus at the falling edge, release just after the rising edge
  task automatic cyc(input logic we, input logic [4:0] widx, input logic [31:0] wval,
                     input logic sch, input logic fl, input logic [4:0] lidx,
                     input logic [31:0] lval, input logic [31:0] lmask);
    @(negedge clk);
    wr_en = we; wr_idx = widx; wr_val = wval;
    ld_sched = sch; ld_flush = fl; ld_idx = lidx; ld_val = lval; ld_mask = lmask;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic chk0(input logic [4:0] idx, input logic [31:0] exp, input string req);
    rd0_idx = idx;
    #1;
    n_checks++;
    if (rd0_val !== exp) begin
      n_errors++;
      $display("FAIL %s: port0 r%0d actual %h expected %h", req, idx, rd0_val, exp);
    end
  endtask

  task automatic chk1(input logic [4:0] idx, input logic [31:0] exp, input string req);
    rd1_idx = idx;
    #1;
    n_checks++;
    if (rd1_val !== exp) begin
      n_errors++;
      $display("FAIL %s: port1 r%0d actual %h expected %h", req, idx, rd1_val, exp);
    end
  endtask

  logic done;

  initial begin
    done = 1'b0;
    #(200000 * 10);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    rst_n = 1'b0;
    rd0_idx = '0;
    rd1_idx = '0;
    idle_inputs();
    #22;
    // R1: all registers clear during reset, on both ports
    for (int i = 0; i < 32; i++) begin
      chk0(5'(i), 32'h0, "R1");
      chk1(5'(i), 32'h0, "R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      logic [111:0] v;
      logic [1:0]   op;
      string        tag;
      v  = VECS[k];
      op = v[111:110];
      tag = $sformatf("R%0d", v[3:0]);
      cyc(op == 2'd1, v[109:105], v[104:73],
          op == 2'd2, op == 2'd3, v[109:105], v[104:73], v[72:41]);
      chk0(v[40:36], v[35:4], tag);
    end

    // R2: both ports read different registers at once
    rd0_idx = 5'd5;
    rd1_idx = 5'd7;
    #1;
    n_checks++;
    if (rd0_val !== 32'hAAAA55CC || rd1_val !== 32'hDEAD5678) begin
      n_errors++;
      $display("FAIL R2: actual %h/%h expected aaaa55cc/dead5678", rd0_val, rd1_val);
    end

    // R9: direct write and commit on the same register at the same edge
    cyc(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 5'd9, 32'h11111111, 32'hFFFFFFFF);
    cyc(1'b1, 5'd9, 32'h22222222, 1'b0, 1'b1, 5'd0, 32'h0, 32'h0);
    chk0(5'd9, 32'h22222222, "R9");

    // R10: schedule and flush together commit the old load and discard the new one
    cyc(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 5'd10, 32'hFFFFFF0F, 32'h000000FF);
    cyc(1'b0, 5'd0, 32'h0, 1'b1, 1'b1, 5'd11, 32'h00000077, 32'hFFFFFFFF);
    chk0(5'd10, 32'h0000000F, "R10");
    cyc(1'b0, 5'd0, 32'h0, 1'b0, 1'b1, 5'd0, 32'h0, 32'h0);
    chk0(5'd11, 32'h00000000, "R10");

    // R1: reset mid-run clears registers and the pending slot
    cyc(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 5'd5, 32'h99999999, 32'hFFFFFFFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk0(5'd5, 32'h0, "R1");
    chk1(5'd9, 32'h0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cyc(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 5'd3, 32'h000000FF, 32'h000000FF);
    chk0(5'd5, 32'h0, "R1");
    cyc(1'b0, 5'd0, 32'h0, 1'b0, 1'b1, 5'd0, 32'h0, 32'h0);
    chk0(5'd3, 32'h000000FF, "R7");
    chk1(5'd5, 32'h0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule